// File: doc/BRIEF.md
# A/D conversion timing sequencer

This block produces the timing skeleton of a single successive-approximation conversion. A register write port holds four fields. A 3-bit ratio code divides the system clock into a conversion clock. A 2-bit voltage-profile code picks how many conversion clocks the conversion lasts and how many of them are spent sampling. The remaining two fields are an enable bit and a start bit. Once the enable bit is already set, a write that sets the start bit launches one conversion. The sequencer then steps through an optional stabilization prefix, a sampling window and a successive-approximation window. It ends with a one-cycle done pulse and clears the start bit itself.

The prefix of two conversion clocks is inserted when the trigger-wait input is high at the moment of launch. Any write that breaks the programming rules is refused as a whole. A refused write leaves every field as it was and raises a sticky error flag that only reset clears. The analog converter is not part of this block. It consumes the sample-enable and phase outputs.

Reset is asserted asynchronously. Its release passes through a two-stage synchronizer, so the block ignores writes during the first two clock edges after the reset input rises.

Top module: `adc_conv_timer`

## Requirements
- R1: Ratio code 000 gives one conversion clock per 32 system clocks, 001 per 16, 010 per 8, 011 per 6, 100 per 5, 101 per 4 and 110 per 2. A conversion therefore lasts ratio × length system clocks.
- R2: Profile code 01 gives a 19-conversion-clock conversion. Its first 7 clocks are sampling (sample_en_o high) and the other 12 are the approximation window (sar_o high). At most one phase output is high in any cycle.
- R3: Profile code 10 gives a 17-conversion-clock conversion, of which 5 clocks are sampling and 12 are approximation.
- R4: If hw_wait_i is high in the launch cycle, a 2-conversion-clock stabilization window (stab_o high) precedes sampling. Profile 01 at ratio 32 then lasts 672 system clocks.
- R5: done_o pulses for one cycle exactly ratio × length system clocks after the clock edge that accepted the launching write. st_o reads 0 from that same cycle.
- R6: A write carrying ratio code 111, or profile code 00 or 11, is refused.
- R7: A write with start = 1 and enable = 0 is refused.
- R8: A write that raises enable and start from 0 to 1 together is refused.
- R9: A write that changes the ratio or profile code while the stored enable or start bit is 1 is refused.
- R10: Any refused write leaves all four fields unchanged and sets err_o. err_o stays 1 until reset.
- R11: An accepted write with start = 0 during a conversion stops it. All phase outputs drop and no done pulse follows.
- R12: When a write lands on the completing clock edge, the conversion still completes. done_o pulses and st_o reads 0 even if the write carried start = 1, and no new conversion begins. The write's enable field is still stored.
- R13: During reset and for two edges after its release, the fields read ratio 000, profile 01, enable 0, start 0, and err_o, all phase outputs and done_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| wr_div_i | input | 3 | Written ratio code |
| wr_vm_i | input | 2 | Written voltage-profile code |
| wr_en_i | input | 1 | Written enable bit |
| wr_st_i | input | 1 | Written start bit |
| hw_wait_i | input | 1 | Trigger-wait mode; adds the stabilization prefix at launch |
| div_o | output | 3 | Stored ratio code |
| vm_o | output | 2 | Stored profile code |
| en_o | output | 1 | Stored enable bit |
| st_o | output | 1 | Stored start bit |
| err_o | output | 1 | Sticky refused-write flag |
| stab_o | output | 1 | Stabilization window active |
| sample_en_o | output | 1 | Sampling window active |
| sar_o | output | 1 | Approximation window active |
| done_o | output | 1 | One-cycle end-of-conversion pulse |

## Verification
A register write and the completion of a conversion can land on the same clock edge. Completion clears the start bit and emits done, while the write tries to store its own start and enable values. The bench counts system clocks from the launching write and issues a second write timed to reach the block exactly on the final conversion-clock edge. It does this once with enable and start cleared, and once with start held at 1. In both cases it expects done to pulse, start to read 0, the write's enable value to be stored, and no phase output to rise afterwards.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_STAB = 2'd1,
    PH_SAMP = 2'd2,
    PH_SAR  = 2'd3
  } phase_e;

  // system clocks per conversion clock; 0 marks a refused code
  function automatic int unsigned div_ratio(input logic [2:0] code);
    case (code)
      3'd0:    return 32;
      3'd1:    return 16;
      3'd2:    return 8;
      3'd3:    return 6;
      3'd4:    return 5;
      3'd5:    return 4;
      3'd6:    return 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic vm_legal(input logic [1:0] code);
    return (code == 2'b01) || (code == 2'b10);
  endfunction

endpackage

// File: rtl/adc_cfg_regs.sv
module adc_cfg_regs
  import adc_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [2:0] wr_div_i,
  input  logic [1:0] wr_vm_i,
  input  logic       wr_en_i,
  input  logic       wr_st_i,
  input  logic       complete_i,
  output logic [2:0] div_o,
  output logic [1:0] vm_o,
  output logic       en_o,
  output logic       st_o,
  output logic       err_o,
  output logic       launch_o,
  output logic       abort_o
);

  logic [2:0] div_q, div_d;
  logic [1:0] vm_q, vm_d;
  logic       en_q, en_d, st_q, st_d, err_q, err_d;
  logic       bad_code, bad_combo, bad_order, bad_timing, reject, accept;

  always_comb begin
    bad_code   = (div_ratio(wr_div_i) == 0) || !vm_legal(wr_vm_i);
    bad_combo  = wr_st_i && !wr_en_i;
    bad_order  = !en_q && !st_q && wr_en_i && wr_st_i;
    bad_timing = (en_q || st_q) && ((wr_div_i != div_q) || (wr_vm_i != vm_q));
    reject     = wr_i && (bad_code || bad_combo || bad_order || bad_timing);
    accept     = wr_i && !reject;
    launch_o   = accept && wr_st_i && !st_q;
    abort_o    = accept && !wr_st_i && st_q && !complete_i;
  end

  always_comb begin
    div_d = div_q;
    vm_d  = vm_q;
    en_d  = en_q;
    st_d  = st_q;
    err_d = err_q || reject;
    if (accept) begin
      div_d = wr_div_i;
      vm_d  = wr_vm_i;
      en_d  = wr_en_i;
      st_d  = wr_st_i;
    end
    if (complete_i) st_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= 3'd0;
      vm_q  <= 2'b01;
      en_q  <= 1'b0;
      st_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      div_q <= div_d;
      vm_q  <= vm_d;
      en_q  <= en_d;
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  assign div_o = div_q;
  assign vm_o  = vm_q;
  assign en_o  = en_q;
  assign st_o  = st_q;
  assign err_o = err_q;

  assert_codes_legal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_ratio(div_q) != 0) && vm_legal(vm_q));
  assert_start_needs_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(st_q && !en_q));
  assert_fields_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q || st_q) |=> ($stable(div_q) && $stable(vm_q)));
  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);

endmodule

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
  parameter int MAX_RATIO = 32,
  localparam int RW = $clog2(MAX_RATIO + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          clear_i,
  input  logic [RW-1:0] ratio_i,
  output logic          tick_o
);

  logic [RW-1:0] pre_q, pre_d;

  assign tick_o = run_i && (pre_q == ratio_i - RW'(1));

  always_comb begin
    pre_d = pre_q;
    if (clear_i || !run_i || tick_o) pre_d = '0;
    else                             pre_d = pre_q + RW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end

  // every ratio is at least 2, so ticks never touch
  assert_tick_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

endmodule

// File: rtl/adc_phase_seq.sv
module adc_phase_seq
  import adc_seq_pkg::*;
#(
  parameter int STAB_CLKS = 2,
  parameter int A_TOTAL   = 19,
  parameter int A_SAMP    = 7,
  parameter int B_TOTAL   = 17,
  parameter int B_SAMP    = 5,
  localparam int MAXLEN   = (A_TOTAL > B_TOTAL) ? A_TOTAL : B_TOTAL,
  localparam int CW       = $clog2(MAXLEN + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       launch_i,
  input  logic       abort_i,
  input  logic       tick_i,
  input  logic       wait_i,
  input  logic [1:0] vm_i,
  output phase_e     phase_o,
  output logic       complete_o,
  output logic       done_o
);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d, phase_len;
  logic          done_q, last, use_stab;

  generate
    if (STAB_CLKS > 0) begin : g_stab
      assign use_stab = wait_i;
    end else begin : g_nostab
      assign use_stab = 1'b0;
    end
  endgenerate

  always_comb begin
    case (phase_q)
      PH_STAB: phase_len = CW'(STAB_CLKS);
      PH_SAMP: phase_len = (vm_i == 2'b10) ? CW'(B_SAMP) : CW'(A_SAMP);
      PH_SAR:  phase_len = (vm_i == 2'b10) ? CW'(B_TOTAL - B_SAMP) : CW'(A_TOTAL - A_SAMP);
      default: phase_len = CW'(1);
    endcase
    last       = tick_i && (cnt_q == phase_len - CW'(1));
    complete_o = (phase_q == PH_SAR) && last;
  end

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (abort_i) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else if (launch_i) begin
      phase_d = use_stab ? PH_STAB : PH_SAMP;
      cnt_d   = '0;
    end else if (tick_i) begin
      if (last) begin
        cnt_d = '0;
        case (phase_q)
          PH_STAB: phase_d = PH_SAMP;
          PH_SAMP: phase_d = PH_SAR;
          default: phase_d = PH_IDLE;
        endcase
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      done_q  <= complete_o;
    end
  end

  assign phase_o = phase_q;
  assign done_o  = done_q;

  assert_done_when_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (phase_q == PH_IDLE));
  assert_launch_starts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> (phase_q != PH_IDLE));
  assert_abort_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> ((phase_q == PH_IDLE) && !done_q));
  assert_stab_leads_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SAMP) |=> (phase_q != PH_STAB));

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
  import adc_seq_pkg::*;
#(
  parameter int MAX_RATIO = 32,
  parameter int STAB_CLKS = 2,
  parameter int A_TOTAL   = 19,
  parameter int A_SAMP    = 7,
  parameter int B_TOTAL   = 17,
  parameter int B_SAMP    = 5,
  localparam int RW       = $clog2(MAX_RATIO + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [2:0] wr_div_i,
  input  logic [1:0] wr_vm_i,
  input  logic       wr_en_i,
  input  logic       wr_st_i,
  input  logic       hw_wait_i,
  output logic [2:0] div_o,
  output logic [1:0] vm_o,
  output logic       en_o,
  output logic       st_o,
  output logic       err_o,
  output logic       stab_o,
  output logic       sample_en_o,
  output logic       sar_o,
  output logic       done_o
);

  logic          rs1_q, rs_n;
  logic          launch, abort, complete, tick, run;
  logic [RW-1:0] ratio;
  phase_e        phase;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rs1_q <= 1'b0;
      rs_n  <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs_n  <= rs1_q;
    end
  end

  adc_cfg_regs u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rs_n),
    .wr_i       (wr_i),
    .wr_div_i   (wr_div_i),
    .wr_vm_i    (wr_vm_i),
    .wr_en_i    (wr_en_i),
    .wr_st_i    (wr_st_i),
    .complete_i (complete),
    .div_o      (div_o),
    .vm_o       (vm_o),
    .en_o       (en_o),
    .st_o       (st_o),
    .err_o      (err_o),
    .launch_o   (launch),
    .abort_o    (abort)
  );

  assign ratio = RW'(div_ratio(div_o));
  assign run   = (phase != PH_IDLE);

  adc_tick_gen #(.MAX_RATIO(MAX_RATIO)) u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rs_n),
    .run_i   (run),
    .clear_i (launch),
    .ratio_i (ratio),
    .tick_o  (tick)
  );

  adc_phase_seq #(
    .STAB_CLKS (STAB_CLKS),
    .A_TOTAL   (A_TOTAL),
    .A_SAMP    (A_SAMP),
    .B_TOTAL   (B_TOTAL),
    .B_SAMP    (B_SAMP)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rs_n),
    .launch_i   (launch),
    .abort_i    (abort),
    .tick_i     (tick),
    .wait_i     (hw_wait_i),
    .vm_i       (vm_o),
    .phase_o    (phase),
    .complete_o (complete),
    .done_o     (done_o)
  );

  assign stab_o      = (phase == PH_STAB);
  assign sample_en_o = (phase == PH_SAMP);
  assign sar_o       = (phase == PH_SAR);

  assert_single_phase_R2: assert property (@(posedge clk_i) disable iff (!rs_n)
    $onehot0({stab_o, sample_en_o, sar_o}));
  assert_run_needs_start_R12: assert property (@(posedge clk_i) disable iff (!rs_n)
    run |-> st_o);

endmodule

// File: tb/sim_adc_conv_timer.sv
module sim_adc_conv_timer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr;
  logic [2:0] wr_div;
  logic [1:0] wr_vm;
  logic       wr_en, wr_st, hw_wait;
  logic [2:0] div_o;
  logic [1:0] vm_o;
  logic       en_o, st_o, err_o, stab_o, samp_o, sar_o, done_o;

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R13";
  int    cd = 0, cv = 1;

  always #4 clk = ~clk;

  adc_conv_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_div_i(wr_div), .wr_vm_i(wr_vm),
    .wr_en_i(wr_en), .wr_st_i(wr_st), .hw_wait_i(hw_wait),
    .div_o(div_o), .vm_o(vm_o), .en_o(en_o), .st_o(st_o), .err_o(err_o),
    .stab_o(stab_o), .sample_en_o(samp_o), .sar_o(sar_o), .done_o(done_o)
  );

  // ---------------- behavioural reference ----------------
  int m_div, m_vm, m_t, m_len, m_r, m_stc, m_samp, m_rc;
  bit m_en, m_st, m_err, m_run, m_done, m_comp;

  function automatic int ref_ratio(int d);
    case (d)
      0: return 32; 1: return 16; 2: return 8; 3: return 6;
      4: return 5;  5: return 4;  6: return 2; default: return 0;
    endcase
  endfunction

  function automatic bit ref_legal(int d, int v, bit e, bit s);
    if (ref_ratio(d) == 0) return 0;
    if (v != 1 && v != 2) return 0;
    if (s && !e) return 0;
    if (!m_en && !m_st && e && s) return 0;
    if ((m_en || m_st) && (d != m_div || v != m_vm)) return 0;
    return 1;
  endfunction

  task automatic ref_reset();
    m_div = 0; m_vm = 1; m_en = 0; m_st = 0; m_err = 0;
    m_run = 0; m_done = 0; m_t = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rc = 0;
      ref_reset();
    end else if (m_rc < 2) begin
      m_rc++;
      ref_reset();
    end else begin
      m_comp = m_run && (m_t + 1 == m_r * m_len);
      m_done = m_comp;
      if (m_comp) m_run = 0;
      else if (m_run) m_t++;
      if (wr) begin
        if (!ref_legal(int'(wr_div), int'(wr_vm), wr_en, wr_st)) m_err = 1;
        else begin
          if (wr_st && !m_st) begin
            m_run  = 1; m_t = 0;
            m_r    = ref_ratio(int'(wr_div));
            m_stc  = hw_wait ? 2 : 0;
            m_samp = (wr_vm == 2'b01) ? 7 : 5;
            m_len  = ((wr_vm == 2'b01) ? 19 : 17) + m_stc;
          end else if (!wr_st && m_st && !m_comp) begin
            m_run = 0;
          end
          m_div = int'(wr_div); m_vm = int'(wr_vm); m_en = wr_en; m_st = wr_st;
        end
      end
      if (m_comp) m_st = 0;
    end
  end

  // compare every cycle, one time unit before the rising edge
  always @(negedge clk) begin
    logic [12:0] got, exp;
    int u;
    bit es, ep, ec;
    #3;
    u  = m_run ? (m_t / m_r) : 0;
    es = m_run && (u < m_stc);
    ep = m_run && !es && (u < m_stc + m_samp);
    ec = m_run && !es && !ep;
    got = {div_o, vm_o, en_o, st_o, err_o, stab_o, samp_o, sar_o, done_o};
    exp = {m_div[2:0], m_vm[1:0], m_en, m_st, m_err, es, ep, ec, m_done};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s cycle compare: actual %b expected %b", cur_req, got, exp);
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic finish_sim();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic wr_now(input int d, input int v, input bit e, input bit s);
    wr = 1; wr_div = d[2:0]; wr_vm = v[1:0]; wr_en = e; wr_st = s;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic wr_cfg(input int d, input int v, input bit e, input bit s);
    @(negedge clk);
    wr_now(d, v, e, s);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cd = 0; cv = 1;
  endtask

  task automatic set_profile(input int d, input int v);
    wr_cfg(cd, cv, 0, 0);
    wr_cfg(d, v, 0, 0);
    wr_cfg(d, v, 1, 0);
    cd = d; cv = v;
  endtask

  task automatic measure(output int n, output int ns, output int nst);
    n = 0; ns = 0; nst = 0;
    while (!done_o && n < 5000) begin
      ns  += samp_o;
      nst += stab_o;
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_sim();
  end

  initial begin
    int n, ns, nst, dc;
    rst_n = 0; wr = 0; wr_div = 0; wr_vm = 0; wr_en = 0; wr_st = 0; hw_wait = 0;
    repeat (3) @(negedge clk);
    cur_req = "R13";
    chk("R13 div", div_o, 0); chk("R13 vm", vm_o, 1);
    chk("R13 en/st/err", {en_o, st_o, err_o}, 0);
    chk("R13 phases/done", {stab_o, samp_o, sar_o, done_o}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    cur_req = "R2";
    set_profile(0, 1);
    wr_cfg(0, 1, 1, 1);
    measure(n, ns, nst);
    chk("R1 /32 profile 01 length", n, 608);
    chk("R2 sampling cycles", ns, 224);
    chk("R5 start cleared at done", st_o, 0);

    cur_req = "R3";
    set_profile(3, 2);
    wr_cfg(3, 2, 1, 1);
    measure(n, ns, nst);
    chk("R3 /6 profile 10 length", n, 102);
    chk("R3 sampling cycles", ns, 30);

    cur_req = "R4";
    hw_wait = 1;
    set_profile(4, 1);
    wr_cfg(4, 1, 1, 1);
    measure(n, ns, nst);
    hw_wait = 0;
    chk("R4 /5 with prefix length", n, 105);
    chk("R4 stabilization cycles", nst, 10);
    chk("R4 sampling cycles", ns, 35);

    cur_req = "R1";
    foreach (n_dummy_list[i]) begin end
    for (int k = 0; k < 4; k++) begin
      int d;
      d = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 5 : 6;
      set_profile(d, 2);
      wr_cfg(d, 2, 1, 1);
      measure(n, ns, nst);
      chk("R1 ratio length", n, ref_ratio(d) * 17);
    end

    cur_req = "R11";
    wr_cfg(6, 2, 1, 1);
    repeat (5) @(negedge clk);
    wr_now(6, 2, 1, 0);
    dc = 0;
    for (int c = 0; c < 60; c++) begin
      dc += done_o + stab_o + samp_o + sar_o;
      @(negedge clk);
    end
    chk("R11 no activity after stop", dc, 0);
    chk("R11 start reads 0", st_o, 0);

    cur_req = "R12";
    wr_cfg(6, 2, 1, 1);
    repeat (33) @(negedge clk);
    wr_now(6, 2, 0, 0);
    chk("R12 done on collision", done_o, 1);
    chk("R12 enable from write", en_o, 0);
    chk("R12 start cleared", st_o, 0);
    wr_cfg(6, 2, 1, 0);
    wr_cfg(6, 2, 1, 1);
    repeat (33) @(negedge clk);
    wr_now(6, 2, 1, 1);
    chk("R12 done with start held", done_o, 1);
    chk("R12 start cleared, no relaunch", st_o, 0);
    @(negedge clk);
    chk("R12 phases idle after", {stab_o, samp_o, sar_o}, 0);
    chk("R12 no error", err_o, 0);

    cur_req = "R9";
    wr_cfg(3, 2, 1, 0);
    chk("R9 refused change flags error", err_o, 1);
    chk("R9 ratio kept", div_o, 6);

    cur_req = "R10";
    wr_cfg(6, 2, 0, 0);
    chk("R10 error stays set", err_o, 1);
    chk("R10 legal write still taken", en_o, 0);

    cur_req = "R6";
    do_reset();
    wr_cfg(7, 1, 0, 0);
    chk("R6 ratio 111 refused", err_o, 1);
    chk("R6 ratio kept", div_o, 0);
    do_reset();
    wr_cfg(0, 3, 0, 0);
    chk("R6 profile 11 refused", err_o, 1);
    chk("R6 profile kept", vm_o, 1);

    cur_req = "R7";
    do_reset();
    wr_cfg(0, 1, 1, 0);
    wr_cfg(0, 1, 0, 1);
    chk("R7 refused", err_o, 1);
    chk("R7 fields kept", {en_o, st_o}, 2);
    @(negedge clk);
    chk("R7 nothing runs", {stab_o, samp_o, sar_o}, 0);

    cur_req = "R8";
    do_reset();
    wr_cfg(0, 1, 1, 1);
    chk("R8 refused", err_o, 1);
    chk("R8 fields kept", {en_o, st_o}, 0);
    @(negedge clk);
    chk("R8 nothing runs", {stab_o, samp_o, sar_o}, 0);

    repeat (3) @(negedge clk);
    finish_sim();
  end

  int n_dummy_list[1];

endmodule